// File: doc/BRIEF.md
# Programmable NAND Strobe Timing Generator

This block turns single byte-cycle requests into correctly timed strobes for an asynchronous NAND flash bus. Each request is either a write, which drives a data byte onto the bus, or a read, which captures a byte from the bus. The caller supplies a packed 32-bit timing word. From that word the block takes a setup time, a strobe width and a hold time, each in controller clocks, with one set for reads and another for writes.

A request can also be flagged as one that leaves the flash device busy. For such a request the block waits a programmable number of clock pairs after the hold phase. It then polls the ready input and reports completion only once ready is seen high. The sequencing of commands and addresses belongs to the logic above this block. So does any error correction. This block only times individual byte cycles and reports each one with a single-cycle done pulse.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset both strobes are high, the data-drive enable is low, done is low and the block shows it is ready to accept a request.
- R2: The timing word packs eight 4-bit fields. The read set is setup at bits 3:0, hold at 7:4, width at 11:8 and ready wait at 15:12. The write set is setup at 19:16, hold at 23:20, width at 27:24 and ready wait at 31:28. A read uses only the read set and a write uses only the write set.
- R3: After the clock edge that accepts a request, both strobes stay high for setup+1 clocks. During a write the data-drive enable is high and the bus carries the request byte for the whole cycle.
- R4: The strobe of the request type is then held low for width+1 clocks. A write drives only the write strobe and a read drives only the read strobe, and a read never enables the data drive.
- R5: After the strobe rises, a hold phase of hold+1 clocks follows with both strobes high. A write keeps driving its data during this phase. Done then pulses high for exactly one clock.
- R6: A read captures the bus on the clock edge at which the read strobe rises. The captured byte stays on the read-data output until the next read captures a new byte.
- R7: A change to the timing word after a request has been accepted does not affect that byte cycle. It applies from the next accepted request.
- R8: A request is accepted only while ready-to-accept is high, and that signal is low for the whole of a byte cycle. A request held valid during a cycle starts no second cycle before done.
- R9: For a request flagged busy with ready-wait field n, the block waits 2*n clocks after the hold phase. It then samples the ready input every clock, and done follows one clock after the first high sample. With n=0 sampling starts right after the hold phase.
- R10: For a request not flagged busy, the ready input has no effect: done comes right after the hold phase even while ready is low.
- R11: Every setup, width and hold field encodes cycles minus one, so 0 gives one clock and 15 gives sixteen clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_i | input | 32 | Packed timing word (8 fields of 4 bits) |
| req_valid_i | input | 1 | Byte-cycle request present |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_busy_i | input | 1 | Cycle leaves the device busy; wait for ready |
| req_wdata_i | input | 8 | Byte to write |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| done_o | output | 1 | One-clock pulse when a byte cycle completes |
| rdata_o | output | 8 | Last byte captured by a read |
| nand_we_n_o | output | 1 | Write strobe, active low |
| nand_re_n_o | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data driven to the bus |
| nand_dq_oe_o | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Data from the bus |
| nand_rdy_i | input | 1 | Device ready (high) / busy (low) |

## Verification
The bench builds the block with its default parameters: 8-bit data and 4-bit timing fields. At that size every field value is reachable, from the one-clock minimum to the sixteen-clock maximum and a ready wait of up to thirty clocks, within a few hundred cycles per test. The bench measures the lengths of the setup, strobe and tail phases directly from the pins. It changes the bus data just before and just after the strobe rises, which pins down the read capture edge. It raises ready both early and late to separate the fixed wait from the polling.

// File: rtl/nst_pkg.sv
package nst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RWAIT,
        ST_RPOLL
    } nst_state_e;
endpackage

// File: rtl/nst_field_sel.sv
// Splits the timing word into a read set and a write set and picks one.
module nst_field_sel #(
    parameter int FIELD_W = 4,
    localparam int WORD_W = 8 * FIELD_W
) (
    input  logic [WORD_W-1:0]  timing_i,
    input  logic               write_i,
    output logic [FIELD_W-1:0] setup_o,
    output logic [FIELD_W-1:0] width_o,
    output logic [FIELD_W-1:0] hold_o,
    output logic [FIELD_W-1:0] rwait_o
);
    logic [FIELD_W-1:0] setup_v [2];
    logic [FIELD_W-1:0] hold_v  [2];
    logic [FIELD_W-1:0] width_v [2];
    logic [FIELD_W-1:0] wait_v  [2];

    // set 0 = read, set 1 = write; per set: setup, hold, width, ready wait
    for (genvar g = 0; g < 2; g++) begin : g_set
        localparam int BASE = g * 4 * FIELD_W;
        assign setup_v[g] = timing_i[BASE             +: FIELD_W];
        assign hold_v[g]  = timing_i[BASE + FIELD_W   +: FIELD_W];
        assign width_v[g] = timing_i[BASE + 2*FIELD_W +: FIELD_W];
        assign wait_v[g]  = timing_i[BASE + 3*FIELD_W +: FIELD_W];
    end

    assign setup_o = setup_v[write_i];
    assign width_o = width_v[write_i];
    assign hold_o  = hold_v[write_i];
    assign rwait_o = wait_v[write_i];
endmodule

// File: rtl/nst_phase_fsm.sv
// Phase sequencer: setup, strobe, hold, optional ready wait and poll.
module nst_phase_fsm
    import nst_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic               write_i,
    input  logic               busy_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [FIELD_W-1:0] setup_i,
    input  logic [FIELD_W-1:0] width_i,
    input  logic [FIELD_W-1:0] hold_i,
    input  logic [FIELD_W-1:0] rwait_i,
    input  logic [DATA_W-1:0]  dq_i,
    input  logic               rdy_i,
    output nst_state_e         state_o,
    output logic               wr_o,
    output logic [DATA_W-1:0]  wdata_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               done_o
);
    localparam int CNT_W = FIELD_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        nst_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic               wr;
        logic               busy;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] rwait;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               done;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (valid_i) begin
                    r_d.st    = ST_SETUP;
                    r_d.cnt   = {1'b0, setup_i};
                    r_d.wr    = write_i;
                    r_d.busy  = busy_i;
                    r_d.width = width_i;
                    r_d.hold  = hold_i;
                    r_d.rwait = rwait_i;
                    r_d.wdata = wdata_i;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_PULSE;
                    r_d.cnt = {1'b0, r_q.width};
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = ST_HOLD;
                    r_d.cnt = {1'b0, r_q.hold};
                    if (!r_q.wr) begin
                        r_d.rdata = dq_i;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_HOLD: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - ONE;
                end else if (!r_q.busy) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (r_q.rwait == '0) begin
                    r_d.st = ST_RPOLL;
                end else begin
                    r_d.st  = ST_RWAIT;
                    r_d.cnt = {r_q.rwait, 1'b0} - ONE;
                end
            end
            ST_RWAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_RPOLL;
                end else begin
                    r_d.cnt = r_q.cnt - ONE;
                end
            end
            ST_RPOLL: begin
                if (rdy_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;
    assign wr_o    = r_q.wr;
    assign wdata_o = r_q.wdata;
    assign rdata_o = r_q.rdata;
    assign done_o  = r_q.done;
endmodule

// File: rtl/nand_strobe_gen.sv
// Top: byte-cycle strobe generator for an asynchronous NAND bus.
module nand_strobe_gen
    import nst_pkg::*;
#(
    parameter int FIELD_W = 4,
    parameter int DATA_W  = 8,
    localparam int WORD_W = 8 * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] timing_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_busy_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              nand_we_n_o,
    output logic              nand_re_n_o,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe_o,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rdy_i
);
    logic [FIELD_W-1:0] setup_w, width_w, hold_w, rwait_w;
    nst_state_e         state_w;
    logic               wr_w;
    logic               active_w;

    nst_field_sel #(.FIELD_W(FIELD_W)) sel_i (
        .timing_i (timing_i),
        .write_i  (req_write_i),
        .setup_o  (setup_w),
        .width_o  (width_w),
        .hold_o   (hold_w),
        .rwait_o  (rwait_w)
    );

    nst_phase_fsm #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (req_valid_i),
        .write_i  (req_write_i),
        .busy_i   (req_busy_i),
        .wdata_i  (req_wdata_i),
        .setup_i  (setup_w),
        .width_i  (width_w),
        .hold_i   (hold_w),
        .rwait_i  (rwait_w),
        .dq_i     (nand_dq_i),
        .rdy_i    (nand_rdy_i),
        .state_o  (state_w),
        .wr_o     (wr_w),
        .wdata_o  (nand_dq_o),
        .rdata_o  (rdata_o),
        .done_o   (done_o)
    );

    assign active_w     = (state_w == ST_SETUP) || (state_w == ST_PULSE) ||
                          (state_w == ST_HOLD);
    assign req_ready_o  = (state_w == ST_IDLE);
    assign nand_we_n_o  = !((state_w == ST_PULSE) && wr_w);
    assign nand_re_n_o  = !((state_w == ST_PULSE) && !wr_w);
    assign nand_dq_oe_o = active_w && wr_w;
endmodule

// File: rtl/nand_strobe_gen_chk.sv
// Port-level properties of the strobe generator, bound to the top.
module nand_strobe_gen_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              nand_we_n_o,
    input logic              nand_re_n_o,
    input logic              nand_dq_oe_o
);
    // R4: never both strobes low
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n_o && !nand_re_n_o));

    // R4: a read strobe never coincides with driving the bus
    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n_o |-> !nand_dq_oe_o);

    // R5: data still driven right after the write strobe rises
    a_r5_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n_o) |-> nand_dq_oe_o);

    // R5: done lasts one clock
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: while accepting, bus is quiet
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (nand_we_n_o && nand_re_n_o && !nand_dq_oe_o));

    // R8: completion returns the block to accepting
    a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready_o);

    // R6: read data changes only at the read strobe's rising edge
    a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_re_n_o && $past(nand_re_n_o)) |-> $stable(rdata_o));
endmodule

bind nand_strobe_gen nand_strobe_gen_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready_o  (req_ready_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .nand_we_n_o  (nand_we_n_o),
    .nand_re_n_o  (nand_re_n_o),
    .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/nand_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module nand_strobe_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] timing_i = '0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic        req_busy_i = 1'b0;
    logic [7:0]  req_wdata_i = '0;
    logic        req_ready_o, done_o;
    logic [7:0]  rdata_o;
    logic        nand_we_n_o, nand_re_n_o, nand_dq_oe_o;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rdy_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    nand_strobe_gen dut_i (.*);

    // field builders: read set at 3:0/7:4/11:8/15:12, write set at 19:16/23:20/27:24/31:28
    function automatic logic [31:0] rd_tim(input int su, input int hd, input int wd, input int wt);
        return 32'((su & 15) | ((hd & 15) << 4) | ((wd & 15) << 8) | ((wt & 15) << 12));
    endfunction
    function automatic logic [31:0] wr_tim(input int su, input int hd, input int wd, input int wt);
        return rd_tim(su, hd, wd, wt) << 16;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Runs one byte cycle and measures its phases at the pins.
    task automatic do_cycle(input bit wr, input bit busy, input logic [31:0] tim,
                            input logic [31:0] tim_mid, input logic [7:0] wd,
                            input logic [7:0] rdv, input int rdy_at,
                            output int su, output int lo, output int tl,
                            output bit drv_ok);
        int guard = 0;
        @(negedge clk);
        timing_i = tim; req_valid_i = 1'b1; req_write_i = wr;
        req_busy_i = busy; req_wdata_i = wd;
        nand_dq_i = ~rdv; nand_rdy_i = (rdy_at == 0);
        @(negedge clk);
        req_valid_i = 1'b0; timing_i = tim_mid; req_wdata_i = ~wd;
        su = 0; lo = 0; tl = 0; drv_ok = 1'b1;
        while ((wr ? nand_we_n_o : nand_re_n_o) && guard < 600) begin
            if (wr ? !(nand_dq_oe_o && nand_dq_o == wd) : nand_dq_oe_o) drv_ok = 1'b0;
            if (!nand_we_n_o || !nand_re_n_o || req_ready_o) drv_ok = 1'b0;
            su++; guard++; @(negedge clk);
        end
        nand_dq_i = rdv;
        while (!(wr ? nand_we_n_o : nand_re_n_o) && guard < 600) begin
            if (wr ? !(nand_dq_oe_o && nand_dq_o == wd) : nand_dq_oe_o) drv_ok = 1'b0;
            if (!(wr ? nand_re_n_o : nand_we_n_o)) drv_ok = 1'b0;
            lo++; guard++; @(negedge clk);
        end
        nand_dq_i = ~rdv;
        while (!done_o && guard < 600) begin
            if (tl == 0 && wr && !(nand_dq_oe_o && nand_dq_o == wd)) drv_ok = 1'b0;
            if (!nand_we_n_o || !nand_re_n_o || req_ready_o) drv_ok = 1'b0;
            tl++; guard++;
            if (tl == rdy_at) nand_rdy_i = 1'b1;
            @(negedge clk);
        end
        if (guard >= 600) chk(1'b0, "cycle hung", guard, 0);
    endtask

    task automatic t_reset();
        chk(nand_we_n_o && nand_re_n_o, "R1 strobes high", {nand_we_n_o, nand_re_n_o}, 3);
        chk(!nand_dq_oe_o && !done_o, "R1 oe/done low", {nand_dq_oe_o, done_o}, 0);
        chk(req_ready_o, "R1 ready", req_ready_o, 1);
    endtask

    task automatic t_write_basic();
        int su, lo, tl; bit ok;
        logic [31:0] t = wr_tim(2, 1, 3, 0) | rd_tim(5, 6, 7, 0);
        do_cycle(1'b1, 1'b0, t, t, 8'hC3, 8'h00, 0, su, lo, tl, ok);
        chk_eq("R2/R3 write setup", su, 3);
        chk_eq("R2/R4 write width", lo, 4);
        chk_eq("R5 write hold", tl, 2);
        chk(ok, "R3/R4 write drive", ok, 1);
        @(negedge clk);
        chk(!done_o, "R5 done single pulse", done_o, 0);
    endtask

    task automatic t_read_basic();
        int su, lo, tl; bit ok;
        logic [31:0] t = rd_tim(1, 2, 4, 0) | wr_tim(9, 9, 9, 0);
        do_cycle(1'b0, 1'b0, t, t, 8'h00, 8'hA6, 0, su, lo, tl, ok);
        chk_eq("R2/R3 read setup", su, 2);
        chk_eq("R2/R4 read width", lo, 5);
        chk_eq("R5 read hold", tl, 3);
        chk(ok, "R4 read no drive", ok, 1);
        chk_eq("R6 read capture", rdata_o, 8'hA6);
    endtask

    task automatic t_limits();
        int su, lo, tl; bit ok;
        do_cycle(1'b0, 1'b0, 32'h0, 32'h0, 8'h00, 8'h3C, 0, su, lo, tl, ok);
        chk(su == 1 && lo == 1 && tl == 1, "R11 minimum phases", su*100 + lo*10 + tl, 111);
        chk_eq("R6 capture at width 1", rdata_o, 8'h3C);
        do_cycle(1'b1, 1'b0, 32'h0FFF_0000, 32'h0FFF_0000, 8'h81, 8'h00, 0, su, lo, tl, ok);
        chk(su == 16 && lo == 16 && tl == 16, "R11 maximum phases", su*10000 + lo*100 + tl, 161616);
        chk_eq("R6 rdata kept across write", rdata_o, 8'h3C);
    endtask

    task automatic t_mid_change();
        int su, lo, tl; bit ok;
        logic [31:0] t = wr_tim(1, 2, 1, 0);
        do_cycle(1'b1, 1'b0, t, wr_tim(7, 7, 7, 0), 8'h5E, 8'h00, 0, su, lo, tl, ok);
        chk(su == 2 && lo == 2 && tl == 3, "R7 mid-cycle change ignored", su*100 + lo*10 + tl, 223);
        t = wr_tim(7, 7, 7, 0);
        do_cycle(1'b1, 1'b0, t, t, 8'h5E, 8'h00, 0, su, lo, tl, ok);
        chk_eq("R7 new value on next cycle", su, 8);
    endtask

    task automatic t_busy_wait();
        int su, lo, tl; bit ok;
        logic [31:0] t = wr_tim(0, 1, 0, 3);
        do_cycle(1'b1, 1'b1, t, t, 8'h11, 8'h00, 0, su, lo, tl, ok);
        chk_eq("R9 wait 2n then one poll", tl, 9);
        do_cycle(1'b1, 1'b1, t, t, 8'h11, 8'h00, 20, su, lo, tl, ok);
        chk_eq("R9 poll until ready", tl, 20);
        t = rd_tim(0, 0, 0, 0);
        do_cycle(1'b0, 1'b1, t, t, 8'h00, 8'h77, 0, su, lo, tl, ok);
        chk_eq("R9 zero wait polls at once", tl, 2);
    endtask

    task automatic t_no_busy();
        int su, lo, tl; bit ok;
        logic [31:0] t = wr_tim(0, 2, 0, 5);
        do_cycle(1'b1, 1'b0, t, t, 8'h22, 8'h00, 1000, su, lo, tl, ok);
        chk_eq("R10 ready ignored", tl, 3);
        chk(nand_rdy_i == 1'b0, "R10 ready was low", nand_rdy_i, 0);
    endtask

    task automatic t_accept_once();
        int lows = 0; int guard = 0; bit busy_ok = 1'b1;
        @(negedge clk);
        timing_i = 32'h0; req_valid_i = 1'b1; req_write_i = 1'b1;
        req_busy_i = 1'b0; req_wdata_i = 8'h44;
        @(negedge clk);
        while (!done_o && guard < 100) begin
            if (req_ready_o) busy_ok = 1'b0;
            if (!nand_we_n_o) lows++;
            guard++; @(negedge clk);
        end
        req_valid_i = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!nand_we_n_o) lows++;
        end
        chk(busy_ok, "R8 ready low during cycle", busy_ok, 1);
        chk_eq("R8 one cycle for held request", lows, 1);
        chk(req_ready_o, "R8 ready after cycle", req_ready_o, 1);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_read_basic();
        t_limits();
        t_mid_change();
        t_busy_wait();
        t_no_busy();
        t_accept_once();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule